// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and an external 16-bit static RAM that has no clock. The RAM has active-low select, output-enable, write-enable and two byte-lane strobes. The host gives it one request at a time over a valid/ready handshake. A request holds a read/write flag, a word address, write data and two byte-enable bits. The controller turns each request into a strobe sequence on the memory pins. For reads, it returns the selected lanes with a one-cycle valid pulse.

Each analog timing minimum comes from a small per-speed-grade table of nanosecond values. The table is selected by `SPEED_GRADE`: 0 is the fastest bin, 1 the middle and 2 the slowest. Each value is turned into a clock count by ceiling division by `CLK_PERIOD_NS`, and no count is ever less than one cycle. All memory-side outputs are registered. The data pins are given as separate output, output-enable and input vectors, and the pad tristate sits outside this block.

The sequencer has six states:
- `ST_IDLE`: ready is high.
- `ST_WR_SETUP`: address and select are set up.
- `ST_WR_PULSE`: write enable and the lane strobes are low, and data is driven.
- `ST_WR_HOLD`: the strobes are released while select, address and data are kept.
- `ST_RD_ACCESS`: select, output enable and the lane strobes are low.
- `ST_GAP`: the memory is deselected for recovery and bus turnaround.

The transitions are:
- IDLE to WR_SETUP on an accepted write.
- IDLE to RD_ACCESS on an accepted read.
- WR_SETUP to WR_PULSE after one cycle.
- WR_PULSE to WR_HOLD when the pulse count expires.
- WR_HOLD to GAP after one cycle.
- RD_ACCESS to GAP when the access count expires. The read data is captured on this transition.
- GAP to IDLE when the recovery count expires.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted, and after reset until a request arrives, the outputs are idle: `req_ready`=1, every memory strobe is high, `mem_dq_oe`=0 and `rsp_valid`=0. Reset acts at once, without waiting for a clock edge.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. From that edge, `req_ready` stays 0 until the cycle finishes, and it is never 1 while `mem_cs_n` is 0.
- R3: A write goes through these steps in order:
  - In the first cycle after it is taken, `mem_cs_n`=0, `mem_addr` holds the request address and `mem_we_n`=1.
  - Next, `mem_we_n` and the lane strobes go low, and `mem_dq_oe` rises with the write data.
  - Then there is one cycle in which write enable and the lane strobes are high while select, address and data are unchanged and still driven.
  - `mem_oe_n` stays 1 for the whole write.
- R4: Write-enable low lasts at least the write-pulse minimum (40/50/70 ns). Select is low for at least 45/60/80 ns before write enable rises. Driven data is valid for at least 25/30/40 ns before write enable rises. Each minimum is turned into cycles as the ceiling of ns over `CLK_PERIOD_NS`, with a floor of 1.
- R5: `req_be[0]` selects data bits 7:0 through `mem_lb_n`, and `req_be[1]` selects bits 15:8 through `mem_ub_n`. A lane that is not enabled keeps its strobe high and its memory byte unchanged. A write with `req_be`=00 never pulls `mem_we_n` low.
- R6: A read pulls `mem_cs_n`, `mem_oe_n` and the enabled lane strobes low together, with `mem_we_n`=1, in the first cycle after the request is taken. They stay low until the longest of the address, output-enable and lane access times (55/70/100, 25/35/50, 25/35/50 ns) has passed. `mem_dq_i` is sampled on the edge where they are released.
- R7: `rsp_valid` is high for exactly one cycle per read and never for a write. `rsp_rdata` carries the captured lanes, and any lane not enabled reads as zero.
- R8: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. After a read, `mem_dq_oe` stays 0 for at least the output-float time (20/25/30 ns) after `mem_oe_n` rises.
- R9: Select stays high for at least one recovery cycle between requests, and each cycle lasts at least the minimum cycle time. At a 10 ns clock with `SPEED_GRADE`=0, `req_ready` is low for 7 cycles per write and 8 per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data, lanes not enabled are zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Data output enable for the pad |
| mem_dq_i | input | 16 | Data from memory |

## Verification
The hardest case to reach is a read whose data is sampled too early. At the ports this looks no different from a correct read unless the memory itself knows how long it has been selected. The bench therefore models the memory as returning a poison word (0xDEAD) until its select-and-output-enable window has lasted the access time in real nanoseconds. The same model measures the write pulse, the select window and the data window at each rising write enable. Lane masking is reached by writing one lane and then reading each lane separately. Bus turnaround is reached by placing a write right after a read.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_ACCESS,
        ST_GAP
    } ctrl_state_t;

    // timing quantity selectors
    localparam int TQ_CYCLE    = 0;
    localparam int TQ_WPULSE   = 1;
    localparam int TQ_CS_END   = 2;
    localparam int TQ_DSETUP   = 3;
    localparam int TQ_ADDR_ACC = 4;
    localparam int TQ_OE_ACC   = 5;
    localparam int TQ_LANE_ACC = 6;
    localparam int TQ_FLOAT    = 7;

    // nanosecond minimum for one quantity at one grade (0 fastest, 2 slowest)
    function automatic int grade_ns(input int grade, input int quantity);
        int g;
        g = (grade < 0) ? 0 : ((grade > 2) ? 2 : grade);
        case (quantity)
            TQ_CYCLE:    return (g == 0) ? 55 : ((g == 1) ? 70 : 100);
            TQ_WPULSE:   return (g == 0) ? 40 : ((g == 1) ? 50 : 70);
            TQ_CS_END:   return (g == 0) ? 45 : ((g == 1) ? 60 : 80);
            TQ_DSETUP:   return (g == 0) ? 25 : ((g == 1) ? 30 : 40);
            TQ_ADDR_ACC: return (g == 0) ? 55 : ((g == 1) ? 70 : 100);
            TQ_OE_ACC:   return (g == 0) ? 25 : ((g == 1) ? 35 : 50);
            TQ_LANE_ACC: return (g == 0) ? 25 : ((g == 1) ? 35 : 50);
            TQ_FLOAT:    return (g == 0) ? 20 : ((g == 1) ? 25 : 30);
            default:     return 100;
        endcase
    endfunction

    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        return max2(max2(a, b), c);
    endfunction

    function automatic int grade_cycles(input int grade, input int quantity, input int period_ns);
        return ns_to_cycles(grade_ns(grade, quantity), period_ns);
    endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int N_PULSE = 4,
    parameter int N_RD    = 6,
    parameter int N_WGAP  = 1,
    parameter int N_RGAP  = 2,
    parameter int LANES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LANES-1:0] req_be,
    input  logic [LANES-1:0] be_q,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             cs_n,
    output logic             oe_n,
    output logic             we_n,
    output logic [LANES-1:0] lane_n,
    output logic             dq_oe
);

    ctrl_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [LANES-1:0] lane_sel;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign capture   = (state_q == ST_RD_ACCESS) && (cnt_q == '0);
    // lanes come straight from the request on the accepting edge
    assign lane_sel  = (state_q == ST_IDLE) ? req_be : be_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_RD_ACCESS;
                        cnt_d   = CNT_W'(N_RD - 1);
                    end
                end
            end
            ST_WR_SETUP: begin
                state_d = ST_WR_PULSE;
                cnt_d   = CNT_W'(N_PULSE - 1);
            end
            ST_WR_PULSE: begin
                if (cnt_q == '0) begin
                    state_d = ST_WR_HOLD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WR_HOLD: begin
                state_d = ST_GAP;
                cnt_d   = CNT_W'(N_WGAP - 1);
            end
            ST_RD_ACCESS: begin
                if (cnt_q == '0) begin
                    state_d = ST_GAP;
                    cnt_d   = CNT_W'(N_RGAP - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_GAP: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // registered strobes decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n   <= 1'b1;
            oe_n   <= 1'b1;
            we_n   <= 1'b1;
            lane_n <= '1;
            dq_oe  <= 1'b0;
        end else begin
            cs_n  <= !(state_d inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_HOLD, ST_RD_ACCESS});
            oe_n  <= !(state_d == ST_RD_ACCESS);
            we_n  <= !((state_d == ST_WR_PULSE) && (|lane_sel));
            dq_oe <= (state_d inside {ST_WR_PULSE, ST_WR_HOLD}) && (|lane_sel);
            for (int i = 0; i < LANES; i++) begin
                lane_n[i] <= !((state_d inside {ST_WR_PULSE, ST_RD_ACCESS}) && lane_sel[i]);
            end
        end
    end

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [LANES-1:0]  be_q,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] masked;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign masked[g*LANE_W +: LANE_W] =
                be_q[g] ? mem_dq_i[g*LANE_W +: LANE_W] : '0;
        end
    endgenerate

    // request latch: address, data and lanes held for the whole cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dq_o <= '0;
            be_q     <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_dq_o <= req_wdata;
            be_q     <= req_be;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) begin
                rsp_rdata <= masked;
            end
        end
    end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int CLK_PERIOD_NS = 10,
    parameter int SPEED_GRADE   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_be,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [15:0]       mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_i
);

    localparam int DATA_W = 16;
    localparam int LANES  = 2;

    localparam int N_WC  = grade_cycles(SPEED_GRADE, TQ_CYCLE,    CLK_PERIOD_NS);
    localparam int N_WP  = grade_cycles(SPEED_GRADE, TQ_WPULSE,   CLK_PERIOD_NS);
    localparam int N_CW  = grade_cycles(SPEED_GRADE, TQ_CS_END,   CLK_PERIOD_NS);
    localparam int N_DW  = grade_cycles(SPEED_GRADE, TQ_DSETUP,   CLK_PERIOD_NS);
    localparam int N_AA  = grade_cycles(SPEED_GRADE, TQ_ADDR_ACC, CLK_PERIOD_NS);
    localparam int N_OE  = grade_cycles(SPEED_GRADE, TQ_OE_ACC,   CLK_PERIOD_NS);
    localparam int N_BA  = grade_cycles(SPEED_GRADE, TQ_LANE_ACC, CLK_PERIOD_NS);
    localparam int N_FLT = grade_cycles(SPEED_GRADE, TQ_FLOAT,    CLK_PERIOD_NS);

    // select is already low for one setup cycle before the pulse starts
    localparam int N_PULSE = max3(N_WP, N_DW, N_CW - 1);
    localparam int N_WGAP  = max2(1, N_WC - (N_PULSE + 2));
    localparam int N_RD    = max3(N_AA, N_OE, N_BA);
    localparam int N_RGAP  = max3(N_FLT, N_WC - N_RD, 1);
    localparam int CNT_MAX = max3(N_PULSE, N_RD, max2(N_WGAP, N_RGAP));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic             accept;
    logic             capture;
    logic [LANES-1:0] be_q;
    logic [LANES-1:0] lane_n;

    sram_ctrl_fsm #(
        .CNT_W   (CNT_W),
        .N_PULSE (N_PULSE),
        .N_RD    (N_RD),
        .N_WGAP  (N_WGAP),
        .N_RGAP  (N_RGAP),
        .LANES   (LANES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_be    (req_be),
        .be_q      (be_q),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .cs_n      (mem_cs_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .lane_n    (lane_n),
        .dq_oe     (mem_dq_oe)
    );

    sram_ctrl_dpath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .mem_dq_i  (mem_dq_i),
        .be_q      (be_q),
        .mem_addr  (mem_addr),
        .mem_dq_o  (mem_dq_o),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign mem_lb_n = lane_n[0];
    assign mem_ub_n = lane_n[1];

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int CLK_PERIOD_NS = 10,
    parameter int SPEED_GRADE   = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n,
    input logic [15:0]       mem_dq_o,
    input logic              mem_dq_oe
);

    localparam int WP_NS  = grade_ns(SPEED_GRADE, TQ_WPULSE);
    localparam int ACC_NS = max3(grade_ns(SPEED_GRADE, TQ_ADDR_ACC),
                                 grade_ns(SPEED_GRADE, TQ_OE_ACC),
                                 grade_ns(SPEED_GRADE, TQ_LANE_ACC));

    logic [7:0] we_lo_cnt;
    logic [7:0] rd_lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_lo_cnt <= '0;
            rd_lo_cnt <= '0;
        end else begin
            if (!mem_we_n) begin
                if (we_lo_cnt != 8'hFF) we_lo_cnt <= we_lo_cnt + 1'b1;
            end else begin
                we_lo_cnt <= '0;
            end
            if (!mem_oe_n && !mem_cs_n) begin
                if (rd_lo_cnt != 8'hFF) rd_lo_cnt <= rd_lo_cnt + 1'b1;
            end else begin
                rd_lo_cnt <= '0;
            end
        end
    end

    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !req_ready);

    // R3
    write_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n));

    // R3
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_cs_n && $stable(mem_addr) && $stable(mem_dq_o)));

    // R4
    write_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (int'(we_lo_cnt) * CLK_PERIOD_NS >= WP_NS));

    // R5
    write_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !(mem_lb_n && mem_ub_n));

    // R6
    read_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> (int'(rd_lo_cnt) * CLK_PERIOD_NS >= ACC_NS));

    // R7
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

endmodule

bind sram_ctrl sram_ctrl_chk #(
    .ADDR_W        (ADDR_W),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .SPEED_GRADE   (SPEED_GRADE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_lb_n  (mem_lb_n),
    .mem_ub_n  (mem_ub_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;

    localparam int PERIOD = 10;
    localparam int NV     = 12;
    // expected busy cycles at 10 ns, fastest grade (R9)
    localparam int WR_BUSY = 7;
    localparam int RD_BUSY = 8;

    // {write, addr, wdata, be, expected read data}
    localparam logic [50:0] VEC [NV] = '{
        {1'b1, 16'h0011, 16'hA55A, 2'b11, 16'h0000},
        {1'b0, 16'h0011, 16'h0000, 2'b11, 16'hA55A},
        {1'b1, 16'h0022, 16'h1234, 2'b01, 16'h0000},
        {1'b0, 16'h0022, 16'h0000, 2'b11, 16'h0034},
        {1'b1, 16'h0022, 16'hABCD, 2'b10, 16'h0000},
        {1'b0, 16'h0022, 16'h0000, 2'b11, 16'hAB34},
        {1'b0, 16'h0022, 16'h0000, 2'b01, 16'h0034},
        {1'b0, 16'h0022, 16'h0000, 2'b10, 16'hAB00},
        {1'b1, 16'h0011, 16'hFFFF, 2'b00, 16'h0000},
        {1'b0, 16'h0011, 16'h0000, 2'b11, 16'hA55A},
        {1'b1, 16'hFF33, 16'h0F0F, 2'b11, 16'h0000},
        {1'b0, 16'hFF33, 16'h0000, 2'b11, 16'h0F0F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [15:0] mem_addr;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
    logic [15:0] mem_dq_o;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_i = 16'hDEAD;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    sram_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model, sampled on falling edges
    logic [15:0] model_mem [256];
    int  we_cnt = 0, dv_cnt = 0, cs_cnt = 0, rd_cnt = 0, oe_hi_cnt = 100;
    bit  we_prev = 1'b1, dq_oe_prev = 1'b0;
    logic [1:0] lane_prev = 2'b11;

    initial begin
        for (int i = 0; i < 256; i++) model_mem[i] = 16'h0000;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            // R8: never both sides driving
            if (mem_dq_oe && !mem_oe_n) check(1'b0, "R8 contention", 1, 0);
            if (mem_dq_oe && !dq_oe_prev)
                check(oe_hi_cnt * PERIOD >= 20, "R8 turnaround", oe_hi_cnt * PERIOD, 20);
            if (!mem_we_n) begin
                we_cnt++;
                if (mem_dq_oe) dv_cnt++;
            end else if (!we_prev) begin
                check(we_cnt * PERIOD >= 40, "R4 write pulse", we_cnt * PERIOD, 40);
                check(dv_cnt * PERIOD >= 25, "R4 data setup", dv_cnt * PERIOD, 25);
                check(cs_cnt * PERIOD >= 45, "R4 select window", cs_cnt * PERIOD, 45);
                check(mem_dq_oe, "R3 data hold", mem_dq_oe, 1);
                if (!lane_prev[0]) model_mem[mem_addr[7:0]][7:0]  = mem_dq_o[7:0];
                if (!lane_prev[1]) model_mem[mem_addr[7:0]][15:8] = mem_dq_o[15:8];
                we_cnt = 0;
                dv_cnt = 0;
            end
            if (!mem_cs_n) cs_cnt++; else cs_cnt = 0;
            if (mem_oe_n) begin
                if (oe_hi_cnt < 100) oe_hi_cnt++;
            end else begin
                oe_hi_cnt = 0;
            end
            if (!mem_cs_n && !mem_oe_n && mem_we_n) rd_cnt++; else rd_cnt = 0;
            mem_dq_i <= (rd_cnt * PERIOD >= 55) ? model_mem[mem_addr[7:0]] : 16'hDEAD;
            we_prev    = mem_we_n;
            dq_oe_prev = mem_dq_oe;
            lane_prev  = {mem_ub_n, mem_lb_n};
        end
    end

    task automatic do_req(input logic wr, input logic [15:0] a, input logic [15:0] d,
                          input logic [1:0] be, input logic [15:0] exp);
        int low_cnt = 0;
        int nresp = 0;
        int resp_at = 0;
        bit saw_we = 1'b0;
        logic [15:0] got = '0;
        @(negedge clk);
        check(req_ready == 1'b1, "R2 ready before request", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R2 ready drops on accept", req_ready, 0);
        check(mem_cs_n == 1'b0 && mem_addr == a, "R3/R6 select and address", {mem_cs_n, mem_addr}, {1'b0, a});
        if (wr) begin
            check(mem_we_n == 1'b1 && mem_oe_n == 1'b1, "R3 setup cycle strobes", {mem_we_n, mem_oe_n}, 2'b11);
        end else begin
            check(mem_oe_n == 1'b0 && mem_we_n == 1'b1 && {mem_ub_n, mem_lb_n} == ~be,
                  "R6 read strobes", {mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, {2'b01, ~be});
        end
        while (!req_ready && low_cnt < 50) begin
            low_cnt++;
            if (!mem_we_n) saw_we = 1'b1;
            if (wr && mem_oe_n == 1'b0) check(1'b0, "R3 oe during write", 0, 1);
            if (rsp_valid) begin
                nresp++;
                resp_at = low_cnt;
                got = rsp_rdata;
            end
            @(negedge clk);
        end
        if (wr) begin
            check(low_cnt == WR_BUSY, "R9 write busy cycles", low_cnt, WR_BUSY);
            check(nresp == 0, "R7 no response for write", nresp, 0);
            check(saw_we == (|be), "R5 write enable vs lanes", saw_we, |be);
        end else begin
            check(low_cnt == RD_BUSY, "R9 read busy cycles", low_cnt, RD_BUSY);
            check(nresp == 1, "R7 one response pulse", nresp, 1);
            check(resp_at == RD_BUSY - 1, "R6 capture cycle", resp_at, RD_BUSY - 1);
            check(got == exp, "R7 read data", got, exp);
        end
    endtask

    initial begin
        // R1: idle outputs during and after reset
        #(PERIOD * 2 + 2);
        check(req_ready && mem_cs_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe && !rsp_valid,
              "R1 outputs in reset", {req_ready, mem_cs_n, mem_we_n, mem_dq_oe}, 4'b1110);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && mem_cs_n && !mem_dq_oe, "R1 outputs after reset",
              {req_ready, mem_cs_n, mem_dq_oe}, 3'b110);

        for (int v = 0; v < NV; v++) begin
            do_req(VEC[v][50], VEC[v][49:34], VEC[v][33:18], VEC[v][17:16], VEC[v][15:0]);
        end

        // R1: reset in the middle of a read returns everything to idle at once
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0011; req_be = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(mem_oe_n == 1'b0, "R6 read in progress", mem_oe_n, 0);
        rst_n = 1'b0;
        #1;
        check(mem_cs_n && mem_oe_n && mem_lb_n && mem_ub_n && req_ready && !rsp_valid,
              "R1 async reset mid-read", {mem_cs_n, mem_oe_n, req_ready}, 3'b111);
        @(negedge clk);
        rst_n = 1'b1;
        // reads still work afterwards, upper lane only
        do_req(1'b0, 16'h0011, 16'h0000, 2'b10, 16'hA500);
        // R5: lane-free read returns zero
        do_req(1'b0, 16'hFF33, 16'h0000, 2'b00, 16'h0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule